// File: doc/BRIEF.md
# Host-to-Core Interrupt Doorbell

This block gives a host processor a register through which it can ring interrupts into one target processor core. The register holds 28 doorbell lines. When the host writes a 1 to a line, that line's pending flag is set and a level interrupt is driven toward the target core. The target core finishes its handler and returns a one-cycle acknowledge on the same line, which clears the flag. A read of the register returns the live pending state, not stored data, so the host can poll whether a doorbell it rang has been serviced.

Every line is an output and nothing else. A second register location reports the fixed direction of each line and ignores writes. Writes of 0 never withdraw a request: only the target side can retire one. Control and status pins are plain, single-cycle signals. The register port takes a write in any cycle it is enabled and a read in any cycle it is enabled. No stream of data crosses the block, so no valid/ready handshake exists, and the block never applies back-pressure.

Top module: `doorbell_host_irq`

## Requirements
- R1: While reset is asserted and after it is released, every pending flag is 0, every `irq_out` line is 0 and `reg_rd_data` is 0.
- R2: A write with `reg_sel`=0 (doorbell register) sets the pending flag of every line whose `reg_wr_data` bit is 1, and the matching `irq_out` bit is high from the cycle after the write edge.
- R3: A 0 in a doorbell write leaves that line's pending flag unchanged. A pending request cannot be withdrawn by the host.
- R4: An `irq_ack` bit that is high at a clock edge clears that line's pending flag at that edge, unless the same line is being set in the same cycle.
- R5: When a doorbell write of 1 and an acknowledge reach the same line in the same cycle, the line is pending after the edge.
- R6: A read with `reg_sel`=0 loads `reg_rd_data` at the edge where `reg_rd_en` is high. Bit i (i<28) holds line i's pending flag as it was before that edge. `reg_rd_data` holds its value while `reg_rd_en` is low.
- R7: Register bits 31 to 28 always read 0, and write data in those bits has no effect on any line.
- R8: A read with `reg_sel`=1 (direction register) returns 0x0FFFFFFF, with 1 meaning output. Writes to it are ignored and leave every pending flag unchanged.
- R9: Each `irq_out` bit is a level that stays high for as long as its flag is pending with no acknowledge, whatever other lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 doorbell, 1 direction |
| reg_wr_en | input | 1 | Write strobe, one write per cycle high |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe, loads read data at the edge |
| reg_rd_data | output | 32 | Registered read data |
| irq_ack | input | 28 | Per-line acknowledge from the target core |
| irq_out | output | 28 | Per-line level interrupt toward the target core |

## Verification
A wrong pending flag shows at the ports on `irq_out` one cycle after the edge that corrupted it, and on the next doorbell read one cycle after that read is issued. The directed tests read back after every write and every acknowledge, so a flag that is lost, stuck or raised on the wrong line shows within two cycles. The write-versus-acknowledge collision and writes to the direction location are each checked in isolation on chosen lines, while other lines are held pending to catch crosstalk.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_LINES = 28;

  typedef enum logic {
    SEL_DOORBELL  = 1'b0,
    SEL_DIRECTION = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/doorbell_bit_cell.sv
module doorbell_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic pending_o
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending_q <= 1'b0;
    else if (set_i)      pending_q <= 1'b1;
    else if (ack_i)      pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> pending_o); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack_i && !set_i) |=> !pending_o); // R4
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!set_i && !ack_i) |=> $stable(pending_o)); // R9
endmodule

// File: rtl/doorbell_readback.sv
module doorbell_readback
  import doorbell_pkg::*;
#(
  parameter int unsigned W     = REG_W,
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic             sel_i,
  input  logic [LINES-1:0] pending_i,
  output logic [W-1:0]     rd_data_o
);
  localparam int unsigned PAD = W - LINES;

  logic [W-1:0] pend_word;
  logic [W-1:0] dir_word;

  generate
    if (PAD > 0) begin : g_pad
      assign pend_word = {{PAD{1'b0}}, pending_i};
      assign dir_word  = {{PAD{1'b0}}, {LINES{1'b1}}};
    end else begin : g_nopad
      assign pend_word = pending_i;
      assign dir_word  = {LINES{1'b1}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= (sel_i == SEL_DIRECTION) ? dir_word : pend_word;
  end

  AST_RD_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rd_en_i |=> $stable(rd_data_o)); // R6
  AST_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n) (rd_en_i && sel_i == SEL_DOORBELL) |=> rd_data_o[LINES-1:0] == $past(pending_i)); // R6
endmodule

// File: rtl/doorbell_host_irq.sv
module doorbell_host_irq
  import doorbell_pkg::*;
#(
  parameter int unsigned W     = REG_W,
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr_en,
  input  logic [W-1:0]     reg_wr_data,
  input  logic             reg_rd_en,
  output logic [W-1:0]     reg_rd_data,
  input  logic [LINES-1:0] irq_ack,
  output logic [LINES-1:0] irq_out
);
  logic             ring;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] pending;

  assign ring    = reg_wr_en && (reg_sel == SEL_DOORBELL);
  assign set_vec = ring ? reg_wr_data[LINES-1:0] : '0;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      doorbell_bit_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec[i]),
        .ack_i     (irq_ack[i]),
        .pending_o (pending[i])
      );
    end
  endgenerate

  assign irq_out = pending;

  doorbell_readback #(.W(W), .LINES(LINES)) u_rdback (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (reg_rd_en),
    .sel_i     (reg_sel),
    .pending_i (pending),
    .rd_data_o (reg_rd_data)
  );

  AST_DIR_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && reg_sel == SEL_DIRECTION && irq_ack == '0) |=> $stable(irq_out)); // R8
  AST_ZERO_NO_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack == '0) |=> ((irq_out & $past(irq_out)) == $past(irq_out))); // R3
endmodule

// File: tb/tb_doorbell_host_irq.sv
`timescale 1ns/1ps
module tb_doorbell_host_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_rd_data;
  logic [27:0] irq_ack = '0;
  logic [27:0] irq_out;

  int checks = 0;
  int failures = 0;
  logic [27:0] exp_pend = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  doorbell_host_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .irq_ack(irq_ack), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic sel, input logic wr, input logic [31:0] wd,
                       input logic rd, input logic [27:0] ack);
    @(negedge clk);
    reg_sel = sel; reg_wr_en = wr; reg_wr_data = wd; reg_rd_en = rd; irq_ack = ack;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; irq_ack = '0; reg_wr_data = '0;
  endtask

  task automatic read_bell(output logic [31:0] v);
    cycle(1'b0, 1'b0, '0, 1'b1, '0);
    v = reg_rd_data;
  endtask

  task automatic t_reset();
    check("R1 irq_out", {4'h0, irq_out}, 32'h0);
    check("R1 rd_data", reg_rd_data, 32'h0);
  endtask

  task automatic t_ring();
    logic [31:0] v;
    cycle(1'b0, 1'b1, 32'h0000_00A5, 1'b0, '0);
    exp_pend |= 28'h00000A5;
    check("R2 irq_out", {4'h0, irq_out}, {4'h0, exp_pend});
    read_bell(v);
    check("R6 readback", v, {4'h0, exp_pend});
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    cycle(1'b0, 1'b1, 32'h0000_0000, 1'b0, '0);
    check("R3 irq_out", {4'h0, irq_out}, {4'h0, exp_pend});
    cycle(1'b0, 1'b1, 32'h0100_0000, 1'b0, '0);
    exp_pend |= 28'h1000000;
    read_bell(v);
    check("R3 readback", v, {4'h0, exp_pend});
  endtask

  task automatic t_ack();
    logic [31:0] v;
    cycle(1'b0, 1'b0, '0, 1'b0, 28'h0000005);
    exp_pend &= ~28'h0000005;
    check("R4 irq_out", {4'h0, irq_out}, {4'h0, exp_pend});
    read_bell(v);
    check("R4 readback", v, {4'h0, exp_pend});
  endtask

  task automatic t_collide();
    cycle(1'b0, 1'b1, 32'h0000_0300, 1'b0, 28'h0000300);
    exp_pend |= 28'h0000300;
    check("R5 write wins", {4'h0, irq_out}, {4'h0, exp_pend});
    cycle(1'b0, 1'b1, 32'h0000_0100, 1'b0, 28'h0000300);
    exp_pend &= ~28'h0000200;
    check("R5 mixed", {4'h0, irq_out}, {4'h0, exp_pend});
  endtask

  task automatic t_upper();
    logic [31:0] v;
    cycle(1'b0, 1'b1, 32'hF000_0000, 1'b0, '0);
    check("R7 irq_out", {4'h0, irq_out}, {4'h0, exp_pend});
    read_bell(v);
    check("R7 upper zero", {28'h0, v[31:28]}, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    cycle(1'b1, 1'b1, 32'h0000_0000, 1'b0, '0);
    check("R8 write ignored", {4'h0, irq_out}, {4'h0, exp_pend});
    cycle(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
    check("R8 ones ignored", {4'h0, irq_out}, {4'h0, exp_pend});
    cycle(1'b1, 1'b0, '0, 1'b1, '0);
    v = reg_rd_data;
    check("R8 dir read", v, 32'h0FFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 1'b1, 32'h0000_0001 << (k + 12), 1'b0, '0);
      exp_pend |= 28'h1 << (k + 12);
    end
    check("R9 level held", {4'h0, irq_out}, {4'h0, exp_pend});
    cycle(1'b0, 1'b0, '0, 1'b1, '0);
    v = reg_rd_data;
    repeat (3) @(negedge clk);
    check("R6 rd hold", reg_rd_data, v);
    cycle(1'b0, 1'b0, '0, 1'b1, {28{1'b1}});
    check("R6 pre-edge snapshot", reg_rd_data, {4'h0, exp_pend});
    exp_pend = '0;
    check("R4 all cleared", {4'h0, irq_out}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ring();
    t_zero_write();
    t_ack();
    t_collide();
    t_upper();
    t_direction();
    t_level();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule